// File: doc/BRIEF.md
# Shared-Bus Arbiter with Atomic Test-and-Set Lock

This block arbitrates a single shared memory bus among several masters. Each master has its own requester engine that acquires and releases a spin lock held in one memory word. The arbiter grants at most one master per cycle. Unlocked traffic is granted in round-robin order. A master whose granted read carries the lock line keeps the bus for the next cycle. That second cycle writes the value 1 back to the same word, so the read and the write form one test-and-set that no other master can split.

Each requester engine spins politely. It first reads the lock word with ordinary unlocked reads. It issues the locked read and write only after such a poll has returned zero, and it reports the lock as held only when the locked read itself returned zero. After a poll that finds the lock taken, or after a test-and-set that loses, the engine drops its request for a backoff delay. That delay starts at one cycle and doubles after each failure, up to a parameter limit. It returns to one after a successful acquisition. Release is a plain write of zero to the lock word. The memory is outside the block and answers reads in the same cycle as the request.

Top module: `atomic_bus_arbiter`

## Requirements
- R1: While reset is asserted and directly after it, no master is granted, requests nothing and holds the lock, and the memory enable is low.
- R2: At most one grant is high in any cycle, and only for a master whose request is high. The memory enable is high exactly when some grant is high. The memory address is always the lock word address input, and the write enable and write data are those of the granted master.
- R3: In a cycle that is not the second half of a locked pair, the grant goes to the first requesting master found by scanning upward from the index after the last granted master, wrapping from NM-1 to 0. After reset the scan starts at master 0.
- R4: In the cycle after a granted read with the lock line high, only that same master is granted, and the bus cycle is a write of the value 1 to the lock word.
- R5: A requester issues its locked read only if its most recent unlocked poll read of the lock word returned zero.
- R6: After a poll that reads a nonzero word, or after a test-and-set whose locked read returned nonzero, the requester keeps its request low for exactly B cycles. B starts at 1 and doubles after each such failure, saturating at MAX_BACKOFF.
- R7: A master is reported as holding the lock only if its locked read returned zero. At most one master holds the lock at a time, and while any holds it the lock word equals 1.
- R8: The acquired output of a master rises in the cycle right after its test-and-set write cycle. It stays high until the master samples its release input high, and it is low in the cycle after that sample.
- R9: After release, the master performs one unlocked write of 0 to the lock word. A release input while the master does not hold the lock is ignored, and the master makes no bus request.
- R10: The backoff delay B returns to 1 after each successful acquisition, so the first failed poll after a release is followed by a one-cycle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_addr_i | input | AW | Address of the lock word |
| acquire_i | input | NM | Per-master request to start acquiring the lock |
| release_i | input | NM | Per-master request to release a held lock |
| acquired_o | output | NM | Per-master lock-held indication |
| bus_req_o | output | NM | Per-master bus request |
| bus_lock_o | output | NM | Per-master lock line for the atomic pair |
| bus_gnt_o | output | NM | Per-master bus grant |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid in the access cycle |

## Verification
Two masters' acquire attempts can collide on the same lock word. Both polls read zero, and both engines then request the locked read in the same cycle. This is the case where one master's atomic write must land before the other's read. The bench provokes it directly by starting two masters in one cycle while the word is zero. Random acquire and release traffic then repeats it many times. For each grant, the bench's own memory model records the value each master read. It predicts the hold cycle, the acquired outputs and the backoff gaps, and it judges that the losing master saw 1 in its locked read and never reports the lock.

// File: rtl/tas_arb_pkg.sv
package tas_arb_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_POLL,
    RQ_WAIT,
    RQ_TAS_RD,
    RQ_TAS_WR,
    RQ_HELD,
    RQ_REL
  } rq_state_e;

  // doubled delay, clipped at the cap
  function automatic logic [31:0] backoff_step(input logic [31:0] cur, input logic [31:0] cap);
    logic [31:0] dbl;
    dbl = cur << 1;
    return (dbl > cap) ? cap : dbl;
  endfunction

endpackage

// File: rtl/tas_rr_arbiter.sv
module tas_rr_arbiter #(
  parameter int NM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req_i,
  input  logic [NM-1:0] lock_i,
  output logic [NM-1:0] gnt_o,
  output logic          hold_o
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] hold_idx_q;
  logic          hold_q;
  logic [IW-1:0] gidx;
  logic          any_gnt;
  logic          locked_rd;

  function automatic logic [NM-1:0] rr_pick(input logic [NM-1:0] rq, input logic [IW-1:0] start);
    logic [NM-1:0] pick;
    pick = '0;
    for (int k = NM - 1; k >= 0; k--) begin
      int j;
      j = (k + int'(start)) % NM;
      if (rq[j]) pick = NM'(1) << j;
    end
    return pick;
  endfunction

  function automatic logic [IW-1:0] idx_of(input logic [NM-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int k = 0; k < NM; k++) begin
      if (oh[k]) r = r | IW'(k);
    end
    return r;
  endfunction

  always_comb begin
    if (hold_q) begin
      gnt_o = req_i[hold_idx_q] ? (NM'(1) << hold_idx_q) : '0;
    end else begin
      gnt_o = rr_pick(req_i, ptr_q);
    end
  end

  assign gidx      = idx_of(gnt_o);
  assign any_gnt   = |gnt_o;
  assign locked_rd = any_gnt & (|(gnt_o & lock_i)) & ~hold_q;
  assign hold_o    = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q <= locked_rd;
      if (any_gnt) begin
        hold_idx_q <= gidx;
        ptr_q      <= (gidx == IW'(NM - 1)) ? '0 : gidx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tas_requester.sv
module tas_requester
  import tas_arb_pkg::*;
#(
  parameter int DW          = 8,
  parameter int MAX_BACKOFF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_i,
  input  logic          rel_i,
  input  logic          gnt_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          lock_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          acquired_o
);
  localparam int BKW = $clog2(MAX_BACKOFF + 1);

  rq_state_e     st_q, st_d;
  logic [BKW-1:0] bk_q, bk_d, cnt_q, cnt_d, bk_grown;
  logic          zero_q, zero_d;
  logic          rd_zero;

  assign rd_zero  = (rdata_i == '0);
  assign bk_grown = BKW'(backoff_step(32'(bk_q), 32'(MAX_BACKOFF)));

  always_comb begin
    st_d   = st_q;
    bk_d   = bk_q;
    cnt_d  = cnt_q;
    zero_d = zero_q;
    case (st_q)
      RQ_IDLE: if (acq_i) st_d = RQ_POLL;
      RQ_POLL: begin
        if (gnt_i) begin
          if (rd_zero) begin
            st_d = RQ_TAS_RD;
          end else begin
            st_d  = RQ_WAIT;
            cnt_d = bk_q;
            bk_d  = bk_grown;
          end
        end
      end
      RQ_WAIT: begin
        if (cnt_q <= BKW'(1)) st_d = RQ_POLL;
        else cnt_d = cnt_q - BKW'(1);
      end
      RQ_TAS_RD: begin
        if (gnt_i) begin
          zero_d = rd_zero;
          st_d   = RQ_TAS_WR;
        end
      end
      RQ_TAS_WR: begin
        if (gnt_i) begin
          if (zero_q) begin
            st_d = RQ_HELD;
            bk_d = BKW'(1);
          end else begin
            st_d  = RQ_WAIT;
            cnt_d = bk_q;
            bk_d  = bk_grown;
          end
        end
      end
      RQ_HELD: if (rel_i) st_d = RQ_REL;
      RQ_REL:  if (gnt_i) st_d = RQ_IDLE;
      default: st_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RQ_IDLE;
      bk_q   <= BKW'(1);
      cnt_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bk_q   <= bk_d;
      cnt_q  <= cnt_d;
      zero_q <= zero_d;
    end
  end

  assign req_o      = (st_q == RQ_POLL) || (st_q == RQ_TAS_RD) || (st_q == RQ_TAS_WR) || (st_q == RQ_REL);
  assign lock_o     = (st_q == RQ_TAS_RD) || (st_q == RQ_TAS_WR);
  assign we_o       = (st_q == RQ_TAS_WR) || (st_q == RQ_REL);
  assign wdata_o    = (st_q == RQ_TAS_WR) ? DW'(1) : '0;
  assign acquired_o = (st_q == RQ_HELD);

endmodule

// File: rtl/atomic_bus_arbiter.sv
module atomic_bus_arbiter #(
  parameter int NM          = 4,
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int MAX_BACKOFF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lock_addr_i,
  input  logic [NM-1:0] acquire_i,
  input  logic [NM-1:0] release_i,
  output logic [NM-1:0] acquired_o,
  output logic [NM-1:0] bus_req_o,
  output logic [NM-1:0] bus_lock_o,
  output logic [NM-1:0] bus_gnt_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [NM-1:0] we_v;
  logic [DW-1:0] wdata_v [NM];
  logic          arb_hold;

  tas_rr_arbiter #(.NM(NM)) arb_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (bus_req_o),
    .lock_i (bus_lock_o),
    .gnt_o  (bus_gnt_o),
    .hold_o (arb_hold)
  );

  for (genvar m = 0; m < NM; m++) begin : g_master
    tas_requester #(.DW(DW), .MAX_BACKOFF(MAX_BACKOFF)) rq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .acq_i      (acquire_i[m]),
      .rel_i      (release_i[m]),
      .gnt_i      (bus_gnt_o[m]),
      .rdata_i    (mem_rdata_i),
      .req_o      (bus_req_o[m]),
      .lock_o     (bus_lock_o[m]),
      .we_o       (we_v[m]),
      .wdata_o    (wdata_v[m]),
      .acquired_o (acquired_o[m])
    );
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    for (int m = 0; m < NM; m++) begin
      if (bus_gnt_o[m]) begin
        mem_we_o    = mem_we_o | we_v[m];
        mem_wdata_o = mem_wdata_o | wdata_v[m];
      end
    end
  end

  assign mem_en_o   = |bus_gnt_o;
  assign mem_addr_o = lock_addr_i;

endmodule

// File: rtl/atomic_bus_arbiter_chk.sv
module atomic_bus_arbiter_chk #(
  parameter int NM = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] req,
  input logic [NM-1:0] gnt,
  input logic [NM-1:0] lock,
  input logic [NM-1:0] acq,
  input logic          mem_en,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          hold
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_idle_bus_R1: assert (gnt == '0 && acq == '0 && !mem_en)
        else $error("bus active during reset");
    end
  end

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(gnt & lock)) && !mem_we && !hold) |=>
      (hold && gnt == $past(gnt) && mem_we && mem_wdata == DW'(1)));

  assert_mutex_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(acq) <= 1);

  assert_release_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && ((gnt & lock) == '0)) |-> (mem_wdata == '0));

  for (genvar m = 0; m < NM; m++) begin : g_acq
    assert_acq_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acq[m]) |-> $past(gnt[m] & lock[m] & mem_we));
  end

endmodule

bind atomic_bus_arbiter atomic_bus_arbiter_chk #(.NM(NM), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (bus_req_o),
  .gnt       (bus_gnt_o),
  .lock      (bus_lock_o),
  .acq       (acquired_o),
  .mem_en    (mem_en_o),
  .mem_we    (mem_we_o),
  .mem_wdata (mem_wdata_o),
  .hold      (arb_hold)
);

// File: tb/atomic_bus_arbiter_tb_top.sv
module atomic_bus_arbiter_tb_top;
  localparam int NM   = 4;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int MAXB = 8;
  localparam logic [AW-1:0] LOCK_A = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NM-1:0] acq = '0, rel = '0;
  logic [NM-1:0] acquired, breq, block, bgnt;
  logic          men, mwe;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mwd, lock_word;
  logic          poke_en = 1'b0;
  logic [DW-1:0] poke_val = '0;

  atomic_bus_arbiter #(.NM(NM), .AW(AW), .DW(DW), .MAX_BACKOFF(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_addr_i(LOCK_A),
    .acquire_i(acq), .release_i(rel), .acquired_o(acquired),
    .bus_req_o(breq), .bus_lock_o(block), .bus_gnt_o(bgnt),
    .mem_en_o(men), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwd), .mem_rdata_i(lock_word)
  );

  // memory model: only the lock word is ever addressed
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_word <= '0;
    else if (poke_en) lock_word <= poke_val;
    else if (men && mwe) lock_word <= mwd;
  end

  int checks = 0, fails = 0, cyc = 0;
  bit rnd = 1'b0;
  logic [NM-1:0] dir_acq = '0, dir_rel = '0;

  // reference model state
  int ptr_m = 0, hold_idx_m = 0;
  bit hold_m = 1'b0;
  logic [NM-1:0] exp_acq = '0;
  int bk_m [NM], gap_exp [NM], gap_cnt [NM], last_gap [NM], gaps_seen [NM];
  bit gap_pend [NM], poll_zero [NM], tas_zero [NM];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int first_one(input logic [NM-1:0] v);
    for (int k = 0; k < NM; k++) if (v[k]) return k;
    return 0;
  endfunction

  function automatic logic [NM-1:0] rr_expect(input logic [NM-1:0] rq, input int p);
    for (int k = 0; k < NM; k++) begin
      int j;
      j = (p + k) % NM;
      if (rq[j]) return NM'(1) << j;
    end
    return '0;
  endfunction

  task automatic start_gap(input int m);
    gap_pend[m] = 1'b1;
    gap_exp[m]  = bk_m[m];
    gap_cnt[m]  = 0;
    bk_m[m]     = (bk_m[m] * 2 > MAXB) ? MAXB : bk_m[m] * 2;
  endtask

  task automatic check_cycle();
    int gi;
    gi = first_one(bgnt);
    chk($onehot0(bgnt) && ((bgnt & ~breq) == '0), "R2", int'(bgnt), int'(breq));
    chk((men == (bgnt != '0)) && (maddr == LOCK_A), "R2", int'(men), int'(bgnt != '0));
    if (hold_m)
      chk(bgnt == (NM'(1) << hold_idx_m) && mwe && mwd == DW'(1), "R4", int'(bgnt), 1 << hold_idx_m);
    else
      chk(bgnt == rr_expect(breq, ptr_m), "R3", int'(bgnt), int'(rr_expect(breq, ptr_m)));
    chk(acquired == exp_acq, "R8", int'(acquired), int'(exp_acq));
    chk($countones(acquired) <= 1 && (acquired == '0 || lock_word == DW'(1)), "R7",
        int'(acquired), int'(lock_word));
    if (men && mwe && !block[gi]) chk(mwd == '0, "R9", int'(mwd), 0);
    for (int m = 0; m < NM; m++) begin
      if (gap_pend[m]) begin
        if (!breq[m]) gap_cnt[m]++;
        else begin
          chk(gap_cnt[m] == gap_exp[m], "R6", gap_cnt[m], gap_exp[m]);
          last_gap[m] = gap_cnt[m];
          gaps_seen[m]++;
          gap_pend[m] = 1'b0;
        end
      end
    end
  endtask

  // advance the model across the coming clock edge
  task automatic predict();
    int gi;
    logic [NM-1:0] nacq;
    bit hold_n;
    gi = first_one(bgnt);
    nacq = exp_acq & ~rel;
    if (bgnt != '0) begin
      if (block[gi] && !mwe) begin
        chk(poll_zero[gi], "R5", 0, 1);
        poll_zero[gi] = 1'b0;
        tas_zero[gi]  = (lock_word == '0);
      end else if (!block[gi] && !mwe) begin
        poll_zero[gi] = (lock_word == '0);
        if (lock_word != '0) start_gap(gi);
      end else if (block[gi] && mwe) begin
        if (tas_zero[gi]) begin
          nacq[gi] = 1'b1;
          bk_m[gi] = 1;
        end else start_gap(gi);
      end
    end
    hold_n = (bgnt != '0) && block[gi] && !mwe && !hold_m;
    hold_m = hold_n;
    hold_idx_m = gi;
    if (bgnt != '0) ptr_m = (gi + 1) % NM;
    exp_acq = nacq;
  endtask

  task automatic tick();
    @(negedge clk);
    check_cycle();
    if (rnd) begin
      acq = NM'($urandom) & NM'($urandom);
      rel = acquired & ((($urandom % 3) == 0) ? {NM{1'b1}} : '0);
    end else begin
      acq = dir_acq;
      rel = dir_rel;
    end
    predict();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    for (int m = 0; m < NM; m++) begin
      bk_m[m] = 1; gap_pend[m] = 0; poll_zero[m] = 0; tas_zero[m] = 0;
      gaps_seen[m] = 0; last_gap[m] = 0; gap_exp[m] = 0; gap_cnt[m] = 0;
    end

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(bgnt == '0 && acquired == '0 && !men && breq == '0 && block == '0, "R1", int'(breq), 0);
    end
    rst_n = 1'b1;
    tick();
    chk(bgnt == '0 && breq == '0 && acquired == '0, "R1", int'(breq), 0);

    // R7: two masters start together on a free lock; only master 0 may win
    dir_acq = 4'b0011;
    repeat (12) tick();
    chk(acquired == 4'b0001, "R7", int'(acquired), 1);
    dir_acq = 4'b0010;
    dir_rel = 4'b0001;
    tick();
    dir_rel = '0;
    for (int t = 0; t < 80 && !acquired[1]; t++) tick();
    chk(acquired == 4'b0010, "R7", int'(acquired), 2);
    dir_acq = '0;
    dir_rel = 4'b0010;
    tick();
    dir_rel = '0;
    repeat (5) tick();
    chk(acquired == '0 && lock_word == '0, "R9", int'(lock_word), 0);

    // R9: release while not holding is ignored
    dir_rel = 4'b1000;
    repeat (4) begin
      tick();
      chk(breq == '0 && bgnt == '0, "R9", int'(breq), 0);
    end
    dir_rel = '0;

    // R6: lock held by an outside agent, master 2 backs off 1,2,4,8,8
    poke_val = DW'(1); poke_en = 1'b1;
    tick();
    poke_en = 1'b0;
    base = gaps_seen[2];
    dir_acq = 4'b0100;
    for (int t = 0; t < 300 && gaps_seen[2] < base + 5; t++) tick();
    chk(gaps_seen[2] == base + 5 && last_gap[2] == MAXB, "R6", last_gap[2], MAXB);

    // R10: acquire, release, then first failure gap is 1 again
    poke_val = '0; poke_en = 1'b1;
    tick();
    poke_en = 1'b0;
    for (int t = 0; t < 60 && !acquired[2]; t++) tick();
    chk(acquired == 4'b0100, "R8", int'(acquired), 4);
    dir_acq = '0;
    dir_rel = 4'b0100;
    tick();
    dir_rel = '0;
    repeat (4) tick();
    poke_val = DW'(1); poke_en = 1'b1;
    tick();
    poke_en = 1'b0;
    base = gaps_seen[2];
    dir_acq = 4'b0100;
    for (int t = 0; t < 60 && gaps_seen[2] == base; t++) tick();
    chk(gaps_seen[2] == base + 1 && last_gap[2] == 1, "R10", last_gap[2], 1);
    dir_acq = '0;
    poke_val = '0; poke_en = 1'b1;
    tick();
    poke_en = 1'b0;
    for (int t = 0; t < 60 && !acquired[2]; t++) tick();
    dir_rel = 4'b0100;
    tick();
    dir_rel = '0;
    repeat (4) tick();

    // random contention on the lock
    rnd = 1'b1;
    repeat (4000) tick();
    rnd = 1'b0;

    // drain: every master releases and goes idle
    dir_acq = '0;
    dir_rel = '1;
    repeat (300) tick();
    chk(acquired == '0 && lock_word == '0 && breq == '0, "R9", int'(lock_word), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule